// File: doc/BRIEF.md
# Keyed Watchdog Timer with Write-Once Mode

This block is a watchdog for a small controller. It sits on a simple byte-wide register bus with two registers: a mode register and a service register. While the watchdog runs, it counts ticks of a clock-enable input. Software must write the service key to the service register before the count reaches the selected limit. If the limit is reached, the block raises a one-cycle reset request for the rest of the chip.

Misuse of the registers also raises the request at once. Misuse means a wrong key, a key delivered by a single-bit access, or a second attempt to program the mode register. Software may program the mode register only once per reset. That write chooses one of eight power-of-two overflow periods, or stops the watchdog. Once the watchdog is stopped, misuse no longer causes a reset.

When the block issues a request, it returns its own registers to their reset values in the same cycle, so the next boot finds the write-once lock open again. A cause output records whether the last request came from overflow or from misuse. Only the power-on reset clears it.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset, `rst_req` is 0 and `rst_cause` is 2'b00 (none). A read of the service register returns 0x9A. A read of the mode register returns 0x07 (period select all ones, stop bit 0).
- R2: A full-byte write of 0xAC to the service register (address 1) clears the counter. With ticks present on every cycle, the next overflow request comes exactly P cycles after that write.
- R3: A full-byte write of any other value to the service register raises `rst_req` in the cycle after the write, with `rst_cause` = 2'b10 (illegal access).
- R4: A write to the service register with `bus_bitop` = 1 is an illegal access, even when the data is 0xAC.
- R5: A read of the service register always returns 0x9A, including just after the key has been written.
- R6: After each reset, the first full-byte write to the mode register (address 0) is stored. Any later full-byte write to it is an illegal access and does not change it.
- R7: A write to the mode register with `bus_bitop` = 1 is ignored. It changes no bit, raises no request and does not use up the single permitted write.
- R8: Mode bits [2:0] = s select an overflow period P of 2^(MIN_LOG2+s) ticks. Before the first mode write the longest period applies. An accepted mode write also clears the counter.
- R9: If the first mode write has bit 4 set (bit 3 is ignored), counting stops and no overflow occurs. Wrong keys, later mode writes and bit accesses then raise no request, and the mode register keeps the value written.
- R10: The counter advances only in cycles where `tick_en` is 1. Cycles without a tick add their number to the time until overflow.
- R11: `rst_req` lasts exactly one cycle. On it, both registers return to their reset values and the write-once lock is re-armed. An overflow request reports `rst_cause` = 2'b01.
- R12: `rst_cause` holds the cause of the last request until the next request. Only `rst_n` returns it to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_en | input | 1 | Count enable from the selected tick source |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_bitop | input | 1 | Marks the current write as a single-bit manipulation |
| bus_addr | input | ADDR_W | Register address: 0 mode, 1 service |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 2 | Cause of the last request: 00 none, 01 overflow, 10 illegal |

## Verification
The bench predicts every reset request, both its cycle and its cause, and a scoreboard matches each pulse against that prediction. This catches a counter that is off by one tick or that fails to clear on the key. The bench also goes after the write-once lock. It makes a second mode write, which a design without the lock would accept silently. It makes a bit-level mode write, which a careless design would count as the single permitted write or treat as misuse. It writes the key with the bit-access flag set, which a data-only comparison would wrongly accept. In the stopped state, the bench sends every kind of misuse and waits longer than the longest period. A design that let misuse through, or kept counting, would raise a stray request there. A design that failed to re-arm the lock after a request would fault the next boot's first mode write.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'b00,
      CAUSE_OVF     = 2'b01,
      CAUSE_ILLEGAL = 2'b10
   } kwdt_cause_e;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int                ADDR_W    = 4,
   parameter logic [ADDR_W-1:0] MODE_ADDR = '0,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 1,
   parameter logic [BYTE_W-1:0] CLR_KEY   = 8'hAC,
   parameter logic [BYTE_W-1:0] READ_PAT  = 8'h9A,
   parameter int                STOP_BIT  = 4,
   parameter int                SEL_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_bitop,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              hold,
   input  logic              fire,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              illegal,
   output logic              clear,
   output logic              stopped,
   output logic [SEL_W-1:0]  sel
);
   localparam logic [BYTE_W-1:0] MODE_RST = BYTE_W'((1 << SEL_W) - 1);

   logic [BYTE_W-1:0] mode_q;
   logic              locked_q;
   logic              wr_key, wr_mode, key_ok, key_bad, mode_first, mode_again;

   // bus accesses are dropped while the request pulse is out
   assign wr_key     = bus_wr && !hold && (bus_addr == KEY_ADDR);
   assign wr_mode    = bus_wr && !hold && (bus_addr == MODE_ADDR);
   assign key_ok     = wr_key && !bus_bitop && (bus_wdata == CLR_KEY);
   assign key_bad    = wr_key && (bus_bitop || (bus_wdata != CLR_KEY));
   assign mode_first = wr_mode && !bus_bitop && !locked_q;
   assign mode_again = wr_mode && !bus_bitop && locked_q;

   assign stopped = locked_q && mode_q[STOP_BIT];
   assign illegal = !stopped && (key_bad || mode_again);
   assign clear   = key_ok || mode_first;
   assign sel     = mode_q[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_RST;
         locked_q <= 1'b0;
      end else if (fire) begin
         mode_q   <= MODE_RST;
         locked_q <= 1'b0;
      end else if (mode_first) begin
         mode_q   <= bus_wdata;
         locked_q <= 1'b1;
      end
   end

   always_comb begin
      if (bus_addr == KEY_ADDR)       bus_rdata = READ_PAT;
      else if (bus_addr == MODE_ADDR) bus_rdata = mode_q;
      else                            bus_rdata = '0;
   end

   AST_LOCK_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && !fire) |=> $stable(mode_q)); // R6
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int MIN_LOG2    = 10,
   parameter int NUM_PERIODS = 8,
   parameter bit TICK_GATED  = 1'b1,
   localparam int SEL_W = $clog2(NUM_PERIODS),
   localparam int CNT_W = MIN_LOG2 + NUM_PERIODS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             clear,
   input  logic             fire,
   input  logic             stopped,
   input  logic [SEL_W-1:0] sel,
   output logic             ovf
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim [NUM_PERIODS];
   logic             adv;

   for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_lim
      assign lim[g] = CNT_W'((64'd1 << (MIN_LOG2 + g)) - 64'd1);
   end

   if (TICK_GATED) begin : g_tick
      assign adv = tick_en && !stopped;
   end else begin : g_free
      logic unused_tick;
      assign unused_tick = tick_en;
      assign adv = !stopped;
   end

   // a key arriving on the last tick still wins over the overflow
   assign ovf = adv && !clear && (cnt_q == lim[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (fire || clear || stopped)   cnt_q <= '0;
      else if (adv)                        cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim[sel]); // R8
endmodule

// File: rtl/kwdt_resetgen.sv
module kwdt_resetgen
   import kwdt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        illegal,
   input  logic        ovf,
   output logic        fire,
   output logic        rst_req,
   output kwdt_cause_e cause
);
   assign fire = (illegal || ovf) && !rst_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         cause   <= CAUSE_NONE;
      end else begin
         rst_req <= fire;
         if (fire) cause <= illegal ? CAUSE_ILLEGAL : CAUSE_OVF;
      end
   end

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R11
   AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cause != CAUSE_NONE)); // R12
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwdt_pkg::*;
#(
   parameter int                ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] MODE_ADDR   = '0,
   parameter logic [ADDR_W-1:0] KEY_ADDR    = 1,
   parameter logic [7:0]        CLR_KEY     = 8'hAC,
   parameter logic [7:0]        READ_PAT    = 8'h9A,
   parameter int                MIN_LOG2    = 10,
   parameter int                NUM_PERIODS = 8,
   parameter int                STOP_BIT    = 4,
   parameter bit                TICK_GATED  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_bitop,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              rst_req,
   output logic [1:0]        rst_cause
);
   localparam int SEL_W = $clog2(NUM_PERIODS);

   if (NUM_PERIODS < 2 || (1 << SEL_W) != NUM_PERIODS)
      $error("NUM_PERIODS must be a power of two of at least 2");
   if (STOP_BIT < SEL_W || STOP_BIT >= BYTE_W)
      $error("STOP_BIT must lie above the period field inside the byte");
   if (MODE_ADDR == KEY_ADDR)
      $error("register addresses must differ");
   if (MIN_LOG2 < 1 || MIN_LOG2 + NUM_PERIODS > 40)
      $error("period range out of bounds");

   logic             illegal, clear, stopped, ovf, fire;
   logic [SEL_W-1:0] sel;
   kwdt_cause_e      cause;

   kwdt_regs #(
      .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR),
      .CLR_KEY(CLR_KEY), .READ_PAT(READ_PAT), .STOP_BIT(STOP_BIT), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bitop(bus_bitop),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hold(rst_req), .fire(fire),
      .bus_rdata(bus_rdata), .illegal(illegal), .clear(clear),
      .stopped(stopped), .sel(sel)
   );

   kwdt_counter #(
      .MIN_LOG2(MIN_LOG2), .NUM_PERIODS(NUM_PERIODS), .TICK_GATED(TICK_GATED)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clear(clear), .fire(fire),
      .stopped(stopped), .sel(sel), .ovf(ovf)
   );

   kwdt_resetgen u_rgen (
      .clk(clk), .rst_n(rst_n), .illegal(illegal), .ovf(ovf),
      .fire(fire), .rst_req(rst_req), .cause(cause)
   );

   assign rst_cause = cause;

   AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == KEY_ADDR && !bus_bitop && bus_wdata != CLR_KEY
       && !stopped && !rst_req) |=> rst_req); // R3
   AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |=> !rst_req); // R9
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
   localparam int MINL = 4;

   typedef struct {
      int         cyc;
      logic [1:0] cause;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       bus_wr = 1'b0;
   logic       bus_bitop = 1'b0;
   logic [3:0] bus_addr = 4'h0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       rst_req;
   logic [1:0] rst_cause;

   int   nchk = 0, nfail = 0, unexp = 0, cyc = 0;
   bit   prev_req = 1'b0;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   keyed_watchdog #(.MIN_LOG2(MINL)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_bitop(bus_bitop), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rst_req(rst_req), .rst_cause(rst_cause)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rst_req) begin
         chk(!prev_req, "R11", "request wider than one cycle", 1, 0);
         if (exp_q.size() == 0) begin
            unexp++;
            chk(1'b0, "R9", "unexpected request at cycle", cyc, -1);
         end else begin
            exp_t it;
            it = exp_q.pop_front();
            chk(cyc == it.cyc, it.req, "request cycle", cyc, it.cyc);
            chk(rst_cause == it.cause, it.req, "request cause", rst_cause, it.cause);
         end
      end
      prev_req <= rst_req;
   end

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input bit bitop,
                            input bit exp_ill, input string req, output int wcyc);
      @(negedge clk);
      wcyc = cyc + 1;
      if (exp_ill) exp_q.push_back('{wcyc, 2'b10, req});
      bus_addr = a; bus_wdata = d; bus_bitop = bitop; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_bitop = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req,
                     input string what);
      bus_addr = a;
      #1;
      chk(bus_rdata == exp, req, what, bus_rdata, exp);
   endtask

   task automatic drain(input string req);
      for (int n = 0; n < 4000 && exp_q.size() != 0; n++) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, req, "pending expected requests", exp_q.size(), 0);
   endtask

   task automatic power_on;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(rst_req == 1'b0, "R1", "rst_req in reset", rst_req, 0);
      chk(rst_cause == 2'b00, "R1", "cause in reset", rst_cause, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: bench hung, actual running expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      int w, u0;
      power_on();
      chk(rst_cause == 2'b00, "R12", "cause after release", rst_cause, 0);
      rd(4'h1, 8'h9A, "R1", "service read after reset");
      rd(4'h0, 8'h07, "R1", "mode read after reset");

      // default longest period from a key write
      bus_write(4'h1, 8'hAC, 1'b0, 1'b0, "R2", w);
      rd(4'h1, 8'h9A, "R5", "service read after key");
      exp_q.push_back('{w + (1 << (MINL + 7)), 2'b01, "R8"});
      drain("R8");
      repeat (20) @(negedge clk);
      chk(rst_cause == 2'b01, "R12", "cause held after overflow", rst_cause, 1);
      rd(4'h0, 8'h07, "R11", "mode back to reset after overflow");

      // shortest period, then a key restarts it
      bus_write(4'h0, 8'h00, 1'b0, 1'b0, "R8", w);
      rd(4'h0, 8'h00, "R6", "first mode write stored");
      repeat (10) @(negedge clk);
      bus_write(4'h1, 8'hAC, 1'b0, 1'b0, "R2", w);
      exp_q.push_back('{w + (1 << MINL), 2'b01, "R2"});
      drain("R2");

      // second mode write is illegal
      bus_write(4'h0, 8'h03, 1'b0, 1'b0, "R6", w);
      repeat (5) @(negedge clk);
      bus_write(4'h0, 8'h05, 1'b0, 1'b1, "R6", w);
      drain("R6");
      rd(4'h0, 8'h07, "R11", "mode re-armed after illegal");

      // wrong key
      bus_write(4'h1, 8'h55, 1'b0, 1'b1, "R3", w);
      drain("R3");
      chk(rst_cause == 2'b10, "R12", "cause held after illegal", rst_cause, 2);

      // key by bit access
      bus_write(4'h1, 8'hAC, 1'b1, 1'b1, "R4", w);
      drain("R4");

      // bit access to mode is ignored and keeps the single write available
      u0 = unexp;
      bus_write(4'h0, 8'h10, 1'b1, 1'b0, "R7", w);
      repeat (5) @(negedge clk);
      rd(4'h0, 8'h07, "R7", "mode after bit access");
      chk(unexp == u0, "R7", "requests after mode bit access", unexp - u0, 0);
      bus_write(4'h0, 8'h01, 1'b0, 1'b0, "R7", w);
      rd(4'h0, 8'h01, "R7", "mode write accepted after bit access");
      exp_q.push_back('{w + (1 << (MINL + 1)), 2'b01, "R8"});
      drain("R8");

      // stopped watchdog ignores misuse and never overflows
      bus_write(4'h0, 8'h18, 1'b0, 1'b0, "R9", w);
      u0 = unexp;
      bus_write(4'h1, 8'h33, 1'b0, 1'b0, "R9", w);
      bus_write(4'h0, 8'h02, 1'b0, 1'b0, "R9", w);
      bus_write(4'h1, 8'hAC, 1'b1, 1'b0, "R9", w);
      repeat (3000) @(negedge clk);
      chk(unexp == u0, "R9", "requests while stopped", unexp - u0, 0);
      rd(4'h0, 8'h18, "R9", "mode while stopped");

      // power-on reset clears the cause; tick gating
      power_on();
      chk(rst_cause == 2'b00, "R12", "cause after power-on", rst_cause, 0);
      bus_write(4'h0, 8'h00, 1'b0, 1'b0, "R10", w);
      repeat (5) @(negedge clk);
      tick_en = 1'b0;
      repeat (100) @(negedge clk);
      tick_en = 1'b1;
      exp_q.push_back('{w + (1 << MINL) + 100, 2'b01, "R10"});
      drain("R10");
      rd(4'h0, 8'h07, "R11", "mode reset after gated overflow");

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule